// File: doc/BRIEF.md
# Byte Parity Checker and Generator

This block sits in a 36-bit datapath made of four 9-bit bytes. In each byte, bits 7:0 carry data and bit 8 carries parity. Every word that arrives with its valid strobe is checked against a programmable parity sense, either odd or even. When generation is enabled, the top bit of each selected byte is rewritten in flight with a freshly computed parity bit. The word leaves one clock later with a matching valid strobe. A parity-error flag reports whether any checked byte was wrong.

A small control register holds four settings: the parity sense, the coverage (all four bytes, one 18-bit half, or one single byte), the flag behaviour, and the generation enable. The flag either follows each word on its own (flowthrough) or holds an error until it is cleared (latched). When the coverage is a half or a single byte, a lane select input picks which bytes are covered. Bytes outside the selection pass through untouched.

Top module: `byte_parity_unit`

## Requirements
- R1: Reset is synchronous and active high. It clears the control register to zero, which means odd sense, full-word coverage, flowthrough flag and generation off. It also clears `out_valid`, `out_data` and `par_err` to zero.
- R2: When `cfg_wr` is high, the control register loads `cfg_wdata` at that clock edge. The fields are: bit 0 is the sense (0 = odd, 1 = even); bits 2:1 are the coverage; bit 3 is the flag mode (1 = latched); bit 4 is generation enable. The new setting applies to words accepted on later edges, not to the word accepted on the same edge.
- R3: Byte i occupies bits 9i+8 to 9i. A covered byte is in error under odd sense when its nine bits hold an even number of ones. Under even sense, it is in error when they hold an odd number of ones.
- R4: The coverage field selects the bytes as follows. 00 covers all four bytes. 01 covers bytes 0 and 1 when `lane_sel[0]`=0, and bytes 2 and 3 when `lane_sel[0]`=1. 10 covers only byte `lane_sel`. 11 behaves as 00.
- R5: With generation on, bit 8 of every covered byte in `out_data` is replaced by the parity of its bits 7:0 under the current sense. After this, the byte has the correct parity.
- R6: Bits 7:0 of every byte, and the whole of every byte that is not covered (or every byte, when generation is off), reach `out_data` unchanged.
- R7: In flowthrough mode, `par_err` one cycle after a valid word is the OR of the error bits of that word's covered bytes. After a cycle with no valid word, `par_err` is 0, and `err_clr` has no effect.
- R8: In latched mode, an error in a valid word sets `par_err`, and `par_err` then holds until `err_clr` or reset. When `err_clr` arrives in the same cycle as an erroneous word, the clear wins.
- R9: `out_valid` follows `in_valid` with one cycle of latency. `out_data` changes only after a valid word and holds otherwise.
- R10: Checking uses the incoming parity bit, before any generation. A bad word is flagged even when generation corrects it on the way out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control register write value |
| lane_sel | input | 2 | Selects the covered half or byte |
| err_clr | input | 1 | Clears the latched error flag |
| in_valid | input | 1 | Input word valid |
| in_data | input | 36 | Input word, four 9-bit bytes |
| out_valid | output | 1 | Output word valid, one cycle after input |
| out_data | output | 36 | Output word, possibly with rewritten parity bits |
| par_err | output | 1 | Parity error flag |

## Verification
The bench places errors in bytes outside the selected half or byte. A design that decodes the lane select wrongly would flag these errors, or rewrite their parity bits. It also writes the control register in the same cycle as a word. A design that applies the new setting one edge early would check that word under the wrong sense. In latched mode, the bench drives a clear together with a bad word; if the error has priority over the clear, the flag comes out set. Finally, it feeds words with wrong parity while generation is on. A design that checked the rewritten bits instead of the incoming ones would stay silent on these words.

// File: rtl/parity_pkg.sv
package parity_pkg;

    localparam int BYTE_W    = 9;
    localparam int DATA_BITS = BYTE_W - 1;
    localparam int LANES     = 4;

    typedef enum logic [1:0] {
        GR_FULL = 2'b00,
        GR_HALF = 2'b01,
        GR_BYTE = 2'b10,
        GR_WIDE = 2'b11
    } gran_e;

    // Packed MSB first: gen_en is bit 4, even_sense is bit 0.
    typedef struct packed {
        logic  gen_en;
        logic  latch_mode;
        gran_e gran;
        logic  even_sense;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Parity bit that makes a byte satisfy the chosen sense.
    function automatic logic fill_bit(input logic [DATA_BITS-1:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction

    // One when a full byte violates the chosen sense.
    function automatic logic sense_miss(input logic [BYTE_W-1:0] b, input logic even);
        return even ? (^b) : ~(^b);
    endfunction

endpackage

// File: rtl/parity_cfg_reg.sv
module parity_cfg_reg
    import parity_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            cfg <= ctrl_t'(wdata);
        end
    end

    // R2: a write is visible on the following cycle
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cfg == $past(wdata)));

    // R2: register keeps its value without a write
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg));

endmodule

// File: rtl/parity_lane_sel.sv
module parity_lane_sel
    import parity_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int SEL_W   = $clog2(N_LANES)
) (
    input  gran_e              gran,
    input  logic [SEL_W-1:0]   lane_sel,
    output logic [N_LANES-1:0] mask
);

    localparam int HALF = N_LANES / 2;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        localparam int HALF_IDX = i / HALF;
        always_comb begin
            case (gran)
                GR_HALF: mask[i] = (lane_sel[0] == HALF_IDX[0]);
                GR_BYTE: mask[i] = (lane_sel == i[SEL_W-1:0]);
                default: mask[i] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/parity_lane.sv
module parity_lane
    import parity_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              sel,
    input  logic              gen_en,
    input  logic              even,
    output logic [BYTE_W-1:0] byte_out,
    output logic              bad
);

    logic fresh;

    always_comb begin
        fresh = fill_bit(byte_in[DATA_BITS-1:0], even);
        bad   = sel & sense_miss(byte_in, even);
        if (sel && gen_en) begin
            byte_out = {fresh, byte_in[DATA_BITS-1:0]};
        end else begin
            byte_out = byte_in;
        end
    end

endmodule

// File: rtl/parity_flag.sv
module parity_flag (
    input  logic clk,
    input  logic rst,
    input  logic latch_mode,
    input  logic clr,
    input  logic hit,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (latch_mode) begin
            if (clr) begin
                flag <= 1'b0;
            end else if (hit) begin
                flag <= 1'b1;
            end
        end else begin
            flag <= hit;
        end
    end

    // R8: clear wins over a simultaneous error
    p_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (latch_mode && clr) |=> !flag);

    // R8: latched flag holds without a clear
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (latch_mode && flag && !clr) |=> flag);

    // R7: flowthrough flag tracks the current word only
    p_flow_track_r7: assert property (@(posedge clk) disable iff (rst)
        (!latch_mode) |=> (flag == $past(hit)));

endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
    import parity_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int SEL_W   = $clog2(N_LANES),
    parameter int WORD_W  = N_LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic [SEL_W-1:0]  lane_sel,
    input  logic              err_clr,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              par_err
);

    ctrl_t               cfg;
    logic [N_LANES-1:0]  mask;
    logic [N_LANES-1:0]  bad;
    logic [WORD_W-1:0]   next_data;
    logic                hit;

    parity_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    parity_lane_sel #(.N_LANES(N_LANES), .SEL_W(SEL_W)) u_sel (
        .gran     (cfg.gran),
        .lane_sel (lane_sel),
        .mask     (mask)
    );

    for (genvar i = 0; i < N_LANES; i++) begin : g_byte
        parity_lane u_lane (
            .byte_in  (in_data[i*BYTE_W +: BYTE_W]),
            .sel      (mask[i]),
            .gen_en   (cfg.gen_en),
            .even     (cfg.even_sense),
            .byte_out (next_data[i*BYTE_W +: BYTE_W]),
            .bad      (bad[i])
        );

        // R6: uncovered bytes leave the lane untouched
        p_unsel_pass_r6: assert property (@(posedge clk) disable iff (rst)
            !mask[i] |-> (next_data[i*BYTE_W +: BYTE_W] == in_data[i*BYTE_W +: BYTE_W]));

        // R5: a generated byte always meets the chosen sense
        p_gen_sense_r5: assert property (@(posedge clk) disable iff (rst)
            (cfg.gen_en && mask[i]) |->
                !sense_miss(next_data[i*BYTE_W +: BYTE_W], cfg.even_sense));
    end

    assign hit = in_valid & (|bad);

    parity_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .latch_mode (cfg.latch_mode),
        .clr        (err_clr),
        .hit        (hit),
        .flag       (par_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_data;
            end
        end
    end

    // R4: at least one byte is always covered
    p_mask_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(mask) >= 1);

    // R9: valid follows input with one cycle of latency
    p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R9: data holds across idle cycles
    p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(out_data));

endmodule

// File: tb/sim_byte_parity_unit.sv
`timescale 1ns/1ps
module sim_byte_parity_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_wdata = '0;
    logic [1:0]  lane_sel = '0;
    logic        err_clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [35:0] in_data = '0;
    logic        out_valid;
    logic [35:0] out_data;
    logic        par_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    bit          m_even, m_latch, m_gen;
    bit [1:0]    m_gran;
    bit          e_valid, e_err;
    bit [35:0]   e_data;
    string       e_tag;

    always #4 clk = ~clk;

    byte_parity_unit u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .lane_sel(lane_sel), .err_clr(err_clr), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .par_err(par_err)
    );

    function automatic bit covered(int i, bit [1:0] g, bit [1:0] ln);
        if (g == 2'b01) return (i / 2) == ln[0];
        if (g == 2'b10) return i == ln;
        return 1;
    endfunction

    // Build a word with correct parity under a sense, then spoil the bytes in badm.
    function automatic bit [35:0] mkword(bit [31:0] d, bit even, bit [3:0] badm);
        bit [35:0] w;
        for (int i = 0; i < 4; i++) begin
            int ones = $countones(d[i*8 +: 8]);
            bit p = even ? ones[0] : ~ones[0];
            w[i*9 +: 9] = {p ^ badm[i], d[i*8 +: 8]};
        end
        return w;
    endfunction

    task automatic cmp(string what, bit [35:0] act, bit [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", e_tag, what, act, exp);
        end
    endtask

    task automatic step(bit r, bit v, bit [35:0] d, bit [1:0] ln, bit c,
                        bit w, bit [4:0] wd, string tag);
        bit err;
        rst = r; in_valid = v; in_data = d; lane_sel = ln; err_clr = c;
        cfg_wr = w; cfg_wdata = wd;
        if (r) begin
            e_valid = 0; e_data = '0; e_err = 0;
            m_even = 0; m_gran = 0; m_latch = 0; m_gen = 0;
        end else begin
            err = 0;
            if (v) begin
                e_data = d;
                for (int i = 0; i < 4; i++) begin
                    if (covered(i, m_gran, ln)) begin
                        int ones9 = $countones(d[i*9 +: 9]);
                        int ones8 = $countones(d[i*9 +: 8]);
                        bit bad = m_even ? ones9[0] : ~ones9[0];
                        err |= bad;
                        if (m_gen) e_data[i*9 + 8] = m_even ? ones8[0] : ~ones8[0];
                    end
                end
            end
            e_valid = v;
            if (m_latch) e_err = c ? 1'b0 : (e_err | (v & err));
            else         e_err = v & err;
            if (w) begin
                m_even = wd[0]; m_gran = wd[2:1]; m_latch = wd[3]; m_gen = wd[4];
            end
        end
        e_tag = tag;
        @(posedge clk);
        @(negedge clk);
        cmp("out_valid R9", {35'b0, out_valid}, {35'b0, e_valid});
        cmp("out_data", out_data, e_data);
        cmp("par_err", {35'b0, par_err}, {35'b0, e_err});
    endtask

    task automatic cfgw(bit [4:0] wd);
        step(0, 0, '0, 0, 0, 1, wd, "R2");
    endtask

    task automatic word(bit [35:0] d, bit [1:0] ln, string tag);
        step(0, 1, d, ln, 0, 0, '0, tag);
    endtask

    task automatic idle(string tag);
        step(0, 0, '0, 0, 0, 0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R9 watchdog expired actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        step(1, 1, 36'hFFFFFFFFF, 0, 0, 1, 5'h1F, "R1");
        step(1, 0, '0, 0, 0, 0, '0, "R1");
        // R1: after reset, odd sense, full coverage, flowthrough
        word(mkword(32'h12345678, 0, 4'h0), 0, "R1");
        word(mkword(32'h12345678, 1, 4'h0), 0, "R1");
        idle("R7");

        // R3/R7: odd sense, full word, error in each byte in turn
        for (int i = 0; i < 4; i++) word(mkword(32'hA5C3_0F81 + i, 0, 4'(1 << i)), 0, "R3");
        word(mkword(32'hDEADBEEF, 0, 4'hF), 0, "R7");
        idle("R7");

        // R2: switch to even on same cycle as a word; that word still odd
        step(0, 1, mkword(32'h01020304, 0, 4'h0), 0, 0, 1, 5'b00001, "R2");
        word(mkword(32'h01020304, 0, 4'h0), 0, "R3");
        word(mkword(32'h01020304, 1, 4'h0), 0, "R3");
        word(mkword(32'hFFFF0000, 1, 4'h2), 0, "R3");

        // R4: half coverage, errors outside the chosen half ignored
        cfgw(5'b00010);
        word(mkword(32'h11223344, 0, 4'hC), 0, "R4");
        word(mkword(32'h11223344, 0, 4'hC), 1, "R4");
        word(mkword(32'h11223344, 0, 4'h3), 1, "R4");
        word(mkword(32'h11223344, 0, 4'h3), 0, "R4");
        word(mkword(32'h11223344, 0, 4'h3), 2, "R4");

        // R4: single byte coverage, each lane
        cfgw(5'b00100);
        for (int ln = 0; ln < 4; ln++) begin
            word(mkword(32'h55AA33CC, 0, 4'(1 << ln)), 2'(ln), "R4");
            word(mkword(32'h55AA33CC, 0, 4'(~(1 << ln))), 2'(ln), "R4");
        end
        // R4: code 11 behaves as full
        cfgw(5'b00110);
        word(mkword(32'h0, 0, 4'h8), 1, "R4");

        // R5/R10: generation, full word, odd then even
        cfgw(5'b10000);
        word(mkword(32'h89ABCDEF, 0, 4'h5), 0, "R10");
        word(mkword(32'h89ABCDEF, 0, 4'h0), 0, "R5");
        cfgw(5'b10001);
        word(mkword(32'h89ABCDEF, 0, 4'h0), 0, "R10");
        // R5/R6: generation in byte mode, other bytes untouched
        cfgw(5'b10100);
        word(mkword(32'h76543210, 1, 4'h0), 2, "R6");
        word(36'hFFFFFFFFF, 3, "R6");
        cfgw(5'b10011);
        word(36'h000000000, 1, "R6");

        // R9: idle gaps keep data
        idle("R9");
        idle("R9");

        // R8: latched mode
        cfgw(5'b01000);
        word(mkword(32'h13579BDF, 0, 4'h2), 0, "R8");
        idle("R8");
        word(mkword(32'h13579BDF, 0, 4'h0), 0, "R8");
        step(0, 0, '0, 0, 1, 0, '0, "R8");
        idle("R8");
        step(0, 1, mkword(32'h2468ACE0, 0, 4'h1), 0, 1, 0, '0, "R8");
        idle("R8");
        word(mkword(32'h2468ACE0, 0, 4'h4), 0, "R8");
        // R7: clear has no effect in flowthrough
        cfgw(5'b00000);
        step(0, 1, mkword(32'h2468ACE0, 0, 4'h4), 0, 1, 0, '0, "R7");

        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            bit [31:0] rv = $urandom;
            bit [35:0] rd = {rv[3:0], 32'($urandom)};
            if (rv[31:28] == 0)      step(0, 0, '0, 0, rv[5], 1, rv[12:8], "R2");
            else if (rv[31:28] == 1) step(1, rv[6], rd, rv[14:13], 0, 0, '0, "R1");
            else step(0, rv[7], rd, rv[14:13], rv[20:18] == 0, 0, '0, "R3");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule